// File: doc/BRIEF.md
# 24-bit Accumulator Processor Core (Multi-Cycle)

This core executes a small accumulator instruction set on 24-bit words. It runs one instruction at a time over several clock cycles. Each instruction is three bytes long, and the core fetches it from a byte-wide synchronous memory. Arithmetic always has the accumulator A as its target and takes its second operand from a memory word. The index register X can be added to the operand address. A link register L holds the return address of a subroutine call. A compare or index-step instruction leaves a three-way condition code, and the conditional jumps test that code.

The memory port handles one byte per cycle. The core presents an address, and the data for that address arrives on `mem_rdata` in the following cycle. A write completes at the clock edge at which `mem_we` is high. The registers A, X, L, PC and SW are brought out as ports for observation. An opcode that is not in the instruction set stops the core, and the core stays stopped until reset.

Top module: `acc_core`

## Requirements
- R1: While the synchronous reset `rst` is high, A, X, L, PC and SW read zero and `halt` is low. After reset is released, fetching starts at byte 0.
- R2: An instruction is read from bytes PC, PC+1 and PC+2, in this order: opcode, then {index bit, address[14:8]}, then address[7:0]. The fetch addresses appear on `mem_addr` in consecutive cycles. PC has grown by 3 after the fourth clock edge of the instruction.
- R3: The operand address is the 15-bit address field when the index bit is 0. When the index bit is 1, it is the address field plus X[14:0].
- R4: A data word is the three bytes at the operand address and the two bytes above it. The byte at the lowest address is the least significant.
- R5: Opcode 00 loads A, 04 loads X and 08 loads L from the operand word. Opcode 18 adds the operand word to A and 1C subtracts it from A, both modulo 2^24. The result shows on the register outputs after the 10th edge of the instruction.
- R6: Opcode 28 compares A with the operand word as signed 24-bit values. It sets SW[1:0] to 01 for less, 10 for equal and 11 for greater. SW[23:2] always reads zero.
- R7: Opcode 3C always jumps to the operand address. Opcodes 38, 30 and 34 jump only when SW[1:0] is 01, 10 or 11 respectively. A taken jump loads PC after the 5th edge of the instruction, and a jump that is not taken leaves PC at the next instruction.
- R8: Opcode 48 copies the address of the next instruction into L and jumps to the operand address. Opcode 4C jumps to the address held in L. Both complete after 5 edges.
- R9: Opcode 2C adds 1 to X, then compares the new X with the operand word as a signed value and sets SW[1:0] as in R6. It completes after 10 edges.
- R10: Opcode 50 replaces A[7:0] with the byte at the operand address and leaves A[23:8] unchanged; it completes after 8 edges. Opcode 54 writes A[7:0] to that single byte; it completes after 6 edges.
- R11: Opcodes 0C, 10 and 14 store A, X and L as three bytes in the order of R4. Each completes after 8 edges. No other instruction writes memory.
- R12: Any other opcode raises `halt` after the 5th edge of the instruction. After that, `halt` stays high, PC is frozen, no register changes and `mem_we` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 15 | Byte address for a read or a write |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 8 | Byte read, valid one cycle after its address |
| halt | output | 1 | High once an undefined opcode has been decoded |
| reg_a | output | 24 | Accumulator |
| reg_x | output | 24 | Index register |
| reg_l | output | 24 | Link register |
| reg_pc | output | 24 | Program counter |
| reg_sw | output | 24 | Status word with the condition code in bits 1:0 |

## Verification
Counted from the first edge of an instruction, each effect has a fixed latency:

| Effect | Edges after the first edge of the instruction |
|---|---|
| PC steps by 3 | 4 |
| Jump, call, return or halt | 5 |
| Byte store | 6 |
| Byte load or word store | 8 |
| Word load, arithmetic, compare or index step | 10 |

The reference model in the bench carries the same latencies. It decodes each instruction from its own copy of memory when the instruction begins, counts clock edges, and applies the PC step and the final effect at the edge the requirements name. At every falling edge it compares all five registers and `halt`. During the fetch cycles it also compares the fetch addresses. After the halt, the written bytes are compared with the model's memory.

// File: rtl/acc_core.sv
module acc_core (
  input  logic        clk,
  input  logic        rst,
  output logic [14:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata,
  output logic        halt,
  output logic [23:0] reg_a,
  output logic [23:0] reg_x,
  output logic [23:0] reg_l,
  output logic [23:0] reg_pc,
  output logic [23:0] reg_sw
);
  localparam int WW = 24;
  localparam int AW = 15;

  localparam logic [7:0] OP_LDA  = 8'h00, OP_LDX  = 8'h04, OP_LDL  = 8'h08;
  localparam logic [7:0] OP_STA  = 8'h0C, OP_STX  = 8'h10, OP_STL  = 8'h14;
  localparam logic [7:0] OP_ADD  = 8'h18, OP_SUB  = 8'h1C, OP_COMP = 8'h28;
  localparam logic [7:0] OP_TIX  = 8'h2C, OP_JEQ  = 8'h30, OP_JGT  = 8'h34;
  localparam logic [7:0] OP_JLT  = 8'h38, OP_J    = 8'h3C, OP_JSUB = 8'h48;
  localparam logic [7:0] OP_RSUB = 8'h4C, OP_LDCH = 8'h50, OP_STCH = 8'h54;

  localparam logic [1:0] CC_LT = 2'b01, CC_EQ = 2'b10, CC_GT = 2'b11;

  typedef enum logic [2:0] {FETCH, DECODE, READ, EXEC, WRITE, STOP} state_t;

  state_t          st;
  logic [1:0]      cnt;
  logic [1:0]      cc;
  logic [7:0]      op, hi, lo;
  logic [WW-1:0]   a, x, l, pc, opnd;

  wire [AW-1:0] ta      = {hi[6:0], lo} + (hi[7] ? x[AW-1:0] : {AW{1'b0}});
  wire          byte_op = (op == OP_LDCH) || (op == OP_STCH);
  wire [1:0]    last_rd = byte_op ? 2'd1 : 2'd3;
  wire [1:0]    last_wr = byte_op ? 2'd0 : 2'd2;
  wire [WW-1:0] sval    = (op == OP_STX) ? x : (op == OP_STL) ? l : a;
  wire [WW-1:0] x_next  = x + 24'd1;
  wire [WW-1:0] ta_ext  = {{(WW-AW){1'b0}}, ta};

  function automatic logic [1:0] cmp3(input logic [WW-1:0] p, input logic [WW-1:0] q);
    if ($signed(p) < $signed(q)) return CC_LT;
    else if (p == q)             return CC_EQ;
    else                         return CC_GT;
  endfunction

  assign mem_addr  = ((st == FETCH) ? pc[AW-1:0] : ta) + {{(AW-2){1'b0}}, cnt};
  assign mem_we    = (st == WRITE);
  assign mem_wdata = sval[{cnt, 3'b000} +: 8];
  assign halt      = (st == STOP);
  assign reg_a     = a;
  assign reg_x     = x;
  assign reg_l     = l;
  assign reg_pc    = pc;
  assign reg_sw    = {{(WW-2){1'b0}}, cc};

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= FETCH;
      cnt  <= 2'd0;
      cc   <= 2'b00;
      op   <= 8'h00;
      hi   <= 8'h00;
      lo   <= 8'h00;
      a    <= '0;
      x    <= '0;
      l    <= '0;
      pc   <= '0;
      opnd <= '0;
    end else begin
      case (st)
        FETCH: begin
          cnt <= cnt + 2'd1;
          case (cnt)
            2'd1: op <= mem_rdata;
            2'd2: hi <= mem_rdata;
            2'd3: begin
              lo <= mem_rdata;
              pc <= pc + 24'd3;
              st <= DECODE;
            end
            default: ;
          endcase
        end
        DECODE: begin
          cnt <= 2'd0;
          st  <= FETCH;
          case (op)
            OP_LDA, OP_LDX, OP_LDL, OP_ADD, OP_SUB,
            OP_COMP, OP_TIX, OP_LDCH:         st <= READ;
            OP_STA, OP_STX, OP_STL, OP_STCH:  st <= WRITE;
            OP_J:    pc <= ta_ext;
            OP_JEQ:  if (cc == CC_EQ) pc <= ta_ext;
            OP_JGT:  if (cc == CC_GT) pc <= ta_ext;
            OP_JLT:  if (cc == CC_LT) pc <= ta_ext;
            OP_JSUB: begin
              l  <= pc;
              pc <= ta_ext;
            end
            OP_RSUB: pc <= l;
            default: st <= STOP;
          endcase
        end
        READ: begin
          if (cnt != 2'd0) opnd[{cnt - 2'd1, 3'b000} +: 8] <= mem_rdata;
          if (cnt == last_rd) begin
            cnt <= 2'd0;
            st  <= EXEC;
          end else begin
            cnt <= cnt + 2'd1;
          end
        end
        EXEC: begin
          st <= FETCH;
          case (op)
            OP_LDA:  a <= opnd;
            OP_LDX:  x <= opnd;
            OP_LDL:  l <= opnd;
            OP_ADD:  a <= a + opnd;
            OP_SUB:  a <= a - opnd;
            OP_COMP: cc <= cmp3(a, opnd);
            OP_TIX: begin
              x  <= x_next;
              cc <= cmp3(x_next, opnd);
            end
            OP_LDCH: a[7:0] <= opnd[7:0];
            default: ;
          endcase
        end
        WRITE: begin
          if (cnt == last_wr) begin
            cnt <= 2'd0;
            st  <= FETCH;
          end else begin
            cnt <= cnt + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt); // R12
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halt |=> (reg_pc == $past(reg_pc)) && (reg_a == $past(reg_a)) && !mem_we); // R12
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == DECODE) |-> (pc == $past(pc) + 24'd3)); // R2
  AST_CC_CODE: assert property (@(posedge clk) disable iff (rst)
    (cc != $past(cc)) |-> (cc != 2'b00)); // R6
  AST_LDCH_KEEP: assert property (@(posedge clk) disable iff (rst)
    (st == EXEC && op == OP_LDCH) |=> (a[23:8] == $past(a[23:8]))); // R10
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (st == FETCH || st == DECODE || st == READ || st == EXEC) |-> !mem_we); // R11
endmodule

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, halt;
  logic [23:0] reg_a, reg_x, reg_l, reg_pc, reg_sw;

  acc_core dut_i (
    .clk(clk), .rst(rst),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .halt(halt), .reg_a(reg_a), .reg_x(reg_x), .reg_l(reg_l), .reg_pc(reg_pc), .reg_sw(reg_sw)
  );

  logic [7:0] mem [0:1023];
  logic [7:0] mm  [0:1023];
  int checks = 0;
  int errors = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= mm[i];
      mem_rdata <= 8'h00;
    end else begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected halted");
    finish_run();
  end

  task automatic put_ins(input int ad, input logic [7:0] op, input bit ix, input logic [14:0] fa);
    mm[ad] = op;
    mm[ad+1] = {ix, fa[14:8]};
    mm[ad+2] = fa[7:0];
  endtask

  task automatic put_w(input int ad, input logic [23:0] w);
    mm[ad] = w[7:0];
    mm[ad+1] = w[15:8];
    mm[ad+2] = w[23:16];
  endtask

  function automatic logic [1:0] cmpf(input logic [23:0] p, input logic [23:0] q);
    if ($signed(p) < $signed(q)) return 2'b01;
    if (p == q) return 2'b10;
    return 2'b11;
  endfunction

  logic [23:0] mA, mX, mL, mPC;
  logic [1:0]  mCC;
  bit          mH;

  task automatic cmp_all(input string req);
    chk(req, "A", {8'h0, reg_a}, {8'h0, mA});
    chk(req, "X", {8'h0, reg_x}, {8'h0, mX});
    chk(req, "L", {8'h0, reg_l}, {8'h0, mL});
    chk(req, "PC", {8'h0, reg_pc}, {8'h0, mPC});
    chk(req, "SW", {8'h0, reg_sw}, {22'h0, mCC});
    chk(req, "halt", {31'h0, halt}, {31'h0, mH});
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mm[i] = 8'h00;
    put_w(16'h100, 24'd5);
    put_w(16'h103, 24'hFFFFFF);
    put_w(16'h106, 24'd10);
    put_w(16'h109, 24'd0);
    put_w(16'h10C, 24'd3);
    mm[16'h300] = 8'h41; mm[16'h301] = 8'h42; mm[16'h302] = 8'h43;
    put_ins(16'h00, 8'h00, 0, 15'h100);
    put_ins(16'h03, 8'h18, 0, 15'h103);
    put_ins(16'h06, 8'h1C, 0, 15'h106);
    put_ins(16'h09, 8'h28, 0, 15'h100);
    put_ins(16'h0C, 8'h34, 0, 15'h3F0);
    put_ins(16'h0F, 8'h38, 0, 15'h015);
    put_ins(16'h12, 8'hFF, 0, 15'h000);
    put_ins(16'h15, 8'h0C, 0, 15'h200);
    put_ins(16'h18, 8'h04, 0, 15'h109);
    put_ins(16'h1B, 8'h50, 1, 15'h300);
    put_ins(16'h1E, 8'h54, 1, 15'h310);
    put_ins(16'h21, 8'h2C, 0, 15'h10C);
    put_ins(16'h24, 8'h38, 0, 15'h01B);
    put_ins(16'h27, 8'h00, 0, 15'h200);
    put_ins(16'h2A, 8'h28, 0, 15'h200);
    put_ins(16'h2D, 8'h30, 0, 15'h033);
    put_ins(16'h30, 8'hFF, 0, 15'h000);
    put_ins(16'h33, 8'h48, 0, 15'h080);
    put_ins(16'h36, 8'h34, 0, 15'h03C);
    put_ins(16'h39, 8'hFF, 0, 15'h000);
    put_ins(16'h3C, 8'h14, 0, 15'h206);
    put_ins(16'h3F, 8'h10, 0, 15'h209);
    put_ins(16'h42, 8'h08, 0, 15'h103);
    put_ins(16'h45, 8'h3C, 0, 15'h04B);
    put_ins(16'h48, 8'hFF, 0, 15'h000);
    put_ins(16'h4B, 8'h01, 0, 15'h000);
    put_ins(16'h80, 8'h00, 0, 15'h106);
    put_ins(16'h83, 8'h28, 0, 15'h100);
    put_ins(16'h86, 8'h4C, 0, 15'h000);

    mA = 0; mX = 0; mL = 0; mPC = 0; mCC = 0; mH = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp_all("R1");
    chk("R1", "fetch address", {17'h0, mem_addr}, 32'h0);
    rst = 1'b0;

    for (int n = 0; n < 200 && !mH; n++) begin
      logic [7:0]  op, b1, b2;
      logic [14:0] ta;
      logic [23:0] w, nA, nX, nL, nPC;
      logic [1:0]  nCC;
      int          lat, wlen;
      logic [23:0] sv;
      string       rq;
      op = mm[mPC[9:0]];
      b1 = mm[mPC[9:0] + 10'd1];
      b2 = mm[mPC[9:0] + 10'd2];
      ta = {b1[6:0], b2} + (b1[7] ? mX[14:0] : 15'd0);
      w  = {mm[ta[9:0] + 10'd2], mm[ta[9:0] + 10'd1], mm[ta[9:0]]};
      nA = mA; nX = mX; nL = mL; nCC = mCC; nPC = mPC + 24'd3;
      lat = 5; wlen = 0; sv = 0; rq = "R7";
      case (op)
        8'h00: begin nA = w; lat = 10; rq = "R5"; end
        8'h04: begin nX = w; lat = 10; rq = "R5"; end
        8'h08: begin nL = w; lat = 10; rq = "R5"; end
        8'h18: begin nA = mA + w; lat = 10; rq = "R5"; end
        8'h1C: begin nA = mA - w; lat = 10; rq = "R5"; end
        8'h28: begin nCC = cmpf(mA, w); lat = 10; rq = "R6"; end
        8'h2C: begin nX = mX + 24'd1; nCC = cmpf(nX, w); lat = 10; rq = "R9"; end
        8'h50: begin nA = {mA[23:8], mm[ta[9:0]]}; lat = 8; rq = "R10"; end
        8'h54: begin sv = mA; wlen = 1; lat = 6; rq = "R10"; end
        8'h0C: begin sv = mA; wlen = 3; lat = 8; rq = "R11"; end
        8'h10: begin sv = mX; wlen = 3; lat = 8; rq = "R11"; end
        8'h14: begin sv = mL; wlen = 3; lat = 8; rq = "R11"; end
        8'h3C: nPC = {9'h0, ta};
        8'h30: if (mCC == 2'b10) nPC = {9'h0, ta};
        8'h34: if (mCC == 2'b11) nPC = {9'h0, ta};
        8'h38: if (mCC == 2'b01) nPC = {9'h0, ta};
        8'h48: begin nL = mPC + 24'd3; nPC = {9'h0, ta}; rq = "R8"; end
        8'h4C: begin nPC = mL; rq = "R8"; end
        default: rq = "R12";
      endcase
      for (int k = 1; k <= lat; k++) begin
        @(posedge clk);
        if (k == 4) mPC = mPC + 24'd3;
        if (k == lat) begin
          mA = nA; mX = nX; mL = nL; mCC = nCC; mPC = nPC;
          if (rq == "R12") mH = 1;
          for (int b = 0; b < wlen; b++) mm[ta[9:0] + 10'(b)] = sv[8*b +: 8];
        end
        @(negedge clk);
        cmp_all(rq);
        if (k <= 2) chk("R2", "fetch address", {17'h0, mem_addr}, {17'h0, mPC[14:0] + 15'(k)});
      end
    end

    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      cmp_all("R12");
      chk("R12", "write strobe after halt", {31'h0, mem_we}, 32'h0);
    end

    chk("R4", "low byte of stored A", {24'h0, mem[10'h200]}, 32'hFA);
    chk("R4", "high byte of stored A", {24'h0, mem[10'h202]}, 32'hFF);
    chk("R8", "stored link low byte", {24'h0, mem[10'h206]}, 32'h36);
    chk("R10", "copied byte at index 2", {24'h0, mem[10'h312]}, 32'h43);
    chk("R3", "indexed byte beyond copy untouched", {24'h0, mem[10'h313]}, 32'h00);
    for (int i = 0; i < 1024; i++) chk("R11", $sformatf("memory byte %0h", i), {24'h0, mem[i]}, {24'h0, mm[i]});
    finish_run();
  end
endmodule